// File: doc/BRIEF.md
# Dual-Channel Aligned PWM Timer

This block is a 10-bit timer that drives two PWM pins, A and B. The counter either ramps up and wraps (edge alignment) or ramps up and back down (centre alignment). In the second case the period is twice as long and each pulse sits symmetrically around the count-zero point. A period-source bit selects between two uses of the compare registers. In one, a coarse 3-bit code sets the period and each compare register sets the duty of its own pin. In the other, compare register A sets the period and only pin B carries PWM.

Each pin has a 2-bit drive selector (forced low, forced high, PWM, or released), an active-level bit and an inversion bit. Three sticky event flags record compare matches for channel A, channel B and the period end. A timer mode keeps the counter and flags running and releases both pins. Period, duty, alignment and period-source settings take effect only at a period boundary, so a waveform never glitches mid-period. A run input holds the counter at zero.

Top module: `pwm_dual_timer`

## Requirements
- R1: With per_from_a=0 the period length P is per_code×128 counts for codes 1 to 7, and 1024 counts for code 0.
- R2: With per_from_a=0 each pin is active while the count is below its own compare value (cmp_a for pin A, cmp_b for pin B). A compare value of 0 is never active, and a compare value of P or more is always active.
- R3: With per_from_a=1 the period P equals cmp_a (0 means 1024) and pin B is active while the count is below cmp_b. Pin A is released (oe_a=0, pin_a=0).
- R4: In edge alignment (centre_mode=0) the count runs 0 to P−1 and wraps to 0. Every active phase starts at count 0.
- R5: In centre alignment the count runs 0 up to P−1 and back down to 1, giving a period of 2P−2. A compare value D with 0<D<P gives 2D−1 active cycles, centred on count 0.
- R6: flags bit 0 (A), bit 1 (B) and bit 2 (period) are set on a match while running and stay set. A 1 in flag_clr clears the matching bit on the next edge, but a set in the same cycle wins. A matches count==cmp_a (count==P−1 when per_from_a=1). B matches count==cmp_b. The period flag matches count==P−1 only when per_from_a=0.
- R7: io code 00 forces the pin low, 01 forces it high, 10 selects PWM and 11 releases it (oe=0, pin=0). Forced levels ignore the active-level and inversion bits.
- R8: A PWM pin shows act_x while active and ~act_x otherwise, then XOR inv_x.
- R9: With timer_mode=1 the counter and flags behave as in PWM mode while both oe outputs are 0 and both pins are 0.
- R10: Period source, alignment, period code and both compare values are captured only when a new period starts (count returns to 0) or while run is low.
- R11: While run is low the count is held at 0, PWM pins show their inactive level and no flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Counter enable |
| timer_mode | input | 1 | 1: plain timer, pins released |
| per_from_a | input | 1 | 1: cmp_a sets period, PWM on B only |
| centre_mode | input | 1 | 1: centre alignment |
| per_code | input | 3 | Coarse period code, steps of 128 |
| cmp_a | input | 10 | Compare value A |
| cmp_b | input | 10 | Compare value B |
| io_a | input | 2 | Drive selector, pin A |
| io_b | input | 2 | Drive selector, pin B |
| act_a | input | 1 | Active level, pin A |
| act_b | input | 1 | Active level, pin B |
| inv_a | input | 1 | PWM inversion, pin A |
| inv_b | input | 1 | PWM inversion, pin B |
| flag_clr | input | 3 | Write-one-to-clear for flags |
| pin_a | output | 1 | Pin A level |
| pin_b | output | 1 | Pin B level |
| oe_a | output | 1 | Pin A output enable |
| oe_b | output | 1 | Pin B output enable |
| flags | output | 3 | Sticky events {period, B, A} |

## Verification
The bench uses the default parameters: a 10-bit counter, a 3-bit period code and a 128-count step. These reach the full 1024-count period through both code 0 and cmp_a=0, and they reach duty values at and beyond the period. Setting the period from cmp_a gives short periods of 20 or even 1 count. Those make the centre-aligned arithmetic, the mid-period capture rule and the flag set-versus-clear race quick to observe.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
  typedef enum logic [1:0] {
    IO_FORCE_LO = 2'b00,
    IO_FORCE_HI = 2'b01,
    IO_PWM      = 2'b10,
    IO_RELEASE  = 2'b11
  } io_sel_e;

  localparam int NUM_CH = 2;
  localparam int NUM_FLAG = 3;
  localparam int FLG_A = 0;
  localparam int FLG_B = 1;
  localparam int FLG_P = 2;
endpackage

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int CNT_W  = 10,
  parameter int CODE_W = 3,
  parameter int STEP   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              per_from_a,
  input  logic              centre_mode,
  input  logic [CODE_W-1:0] per_code,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  output logic              sel_q,
  output logic              centre_q,
  output logic [CNT_W-1:0]  top_q,
  output logic [CNT_W-1:0]  duty_a_q,
  output logic [CNT_W-1:0]  duty_b_q
);
  localparam int LEN_W = CNT_W + 1;
  localparam logic [LEN_W-1:0] FULL_L = LEN_W'(1) << CNT_W;
  localparam logic [LEN_W-1:0] STEP_L = LEN_W'(STEP);

  // Period length in counts for either period source
  function automatic logic [LEN_W-1:0] period_len(
    input logic              from_a,
    input logic [CODE_W-1:0] code,
    input logic [CNT_W-1:0]  ca
  );
    if (from_a)
      return (ca == '0) ? FULL_L : LEN_W'(ca);
    return (code == '0) ? FULL_L : LEN_W'(code) * STEP_L;
  endfunction

  logic [LEN_W-1:0] len_d;
  logic [CNT_W-1:0] top_d;

  always_comb begin
    len_d = period_len(per_from_a, per_code, cmp_a);
    top_d = CNT_W'(len_d - LEN_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      centre_q <= 1'b0;
      top_q    <= CNT_W'(FULL_L - LEN_W'(1));
      duty_a_q <= '0;
      duty_b_q <= '0;
    end else if (load) begin
      sel_q    <= per_from_a;
      centre_q <= centre_mode;
      top_q    <= top_d;
      duty_a_q <= cmp_a;
      duty_b_q <= cmp_b;
    end
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             centre,
  input  logic [CNT_W-1:0] top,
  output logic [CNT_W-1:0] cnt_q,
  output logic             at_top,
  output logic             period_start
);
  logic [CNT_W-1:0] cnt_d;
  logic             up_q;
  logic             up_d;

  assign at_top = (cnt_q == top);

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (!run) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (!centre) begin
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
    end else if (up_q) begin
      if (at_top) begin
        if (top <= CNT_W'(1)) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
          up_d  = 1'b0;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_d = '0;
        up_d  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  assign period_start = (cnt_d == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             run,
  input  logic             hold_off,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] duty,
  input  logic [1:0]       io,
  input  logic             act,
  input  logic             inv,
  output logic             match,
  output logic             pin,
  output logic             oe
);
  logic    active;
  logic    pwm_lvl;
  logic    drv;
  io_sel_e io_e;

  assign match   = (cnt == duty);
  assign active  = run && (cnt < duty);
  assign pwm_lvl = (active ? act : ~act) ^ inv;
  assign io_e    = io_sel_e'(io);

  always_comb begin
    drv = 1'b0;
    oe  = 1'b1;
    unique case (io_e)
      IO_FORCE_LO: drv = 1'b0;
      IO_FORCE_HI: drv = 1'b1;
      IO_PWM:      drv = pwm_lvl;
      IO_RELEASE:  oe  = 1'b0;
      default:     oe  = 1'b0;
    endcase
    if (hold_off) oe = 1'b0;
  end

  assign pin = oe & drv;
endmodule

// File: rtl/pwm_flags.sv
module pwm_flags #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set,
  input  logic [NF-1:0] clr,
  output logic [NF-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr) | set;
  end
endmodule

// File: rtl/pwm_dual_timer.sv
module pwm_dual_timer
  import pwm_timer_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int CODE_W = 3,
  parameter int STEP   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              timer_mode,
  input  logic              per_from_a,
  input  logic              centre_mode,
  input  logic [CODE_W-1:0] per_code,
  input  logic [CNT_W-1:0]  cmp_a,
  input  logic [CNT_W-1:0]  cmp_b,
  input  logic [1:0]        io_a,
  input  logic [1:0]        io_b,
  input  logic              act_a,
  input  logic              act_b,
  input  logic              inv_a,
  input  logic              inv_b,
  input  logic [NUM_FLAG-1:0] flag_clr,
  output logic              pin_a,
  output logic              pin_b,
  output logic              oe_a,
  output logic              oe_b,
  output logic [NUM_FLAG-1:0] flags
);
  logic             sel_q;
  logic             centre_q;
  logic [CNT_W-1:0] top_q;
  logic [CNT_W-1:0] duty_a_q;
  logic [CNT_W-1:0] duty_b_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_top;
  logic             period_start;
  logic             load;

  // Named events for the checker
  assign load = !run || period_start;

  pwm_shadow #(.CNT_W(CNT_W), .CODE_W(CODE_W), .STEP(STEP)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .per_from_a(per_from_a), .centre_mode(centre_mode), .per_code(per_code),
    .cmp_a(cmp_a), .cmp_b(cmp_b),
    .sel_q(sel_q), .centre_q(centre_q), .top_q(top_q),
    .duty_a_q(duty_a_q), .duty_b_q(duty_b_q)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .centre(centre_q), .top(top_q),
    .cnt_q(cnt_q), .at_top(at_top), .period_start(period_start)
  );

  logic [NUM_CH-1:0][CNT_W-1:0] duty_v;
  logic [NUM_CH-1:0][1:0]       io_v;
  logic [NUM_CH-1:0]            act_v, inv_v, off_v, match_v, pin_v, oe_v;

  assign duty_v = {duty_b_q, duty_a_q};
  assign io_v   = {io_b, io_a};
  assign act_v  = {act_b, act_a};
  assign inv_v  = {inv_b, inv_a};
  assign off_v  = {timer_mode, timer_mode | sel_q};

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .run(run), .hold_off(off_v[g]), .cnt(cnt_q), .duty(duty_v[g]),
      .io(io_v[g]), .act(act_v[g]), .inv(inv_v[g]),
      .match(match_v[g]), .pin(pin_v[g]), .oe(oe_v[g])
    );
  end

  logic [NUM_FLAG-1:0] flag_set;
  always_comb begin
    flag_set        = '0;
    flag_set[FLG_A] = run && (sel_q ? at_top : match_v[0]);
    flag_set[FLG_B] = run && match_v[1];
    flag_set[FLG_P] = run && !sel_q && at_top;
  end

  pwm_flags #(.NF(NUM_FLAG)) u_flags (
    .clk(clk), .rst_n(rst_n), .set(flag_set), .clr(flag_clr), .flags_q(flags)
  );

  assign pin_a = pin_v[0];
  assign pin_b = pin_v[1];
  assign oe_a  = oe_v[0];
  assign oe_b  = oe_v[1];
endmodule

// File: rtl/pwm_dual_timer_chk.sv
module pwm_dual_timer_chk #(
  parameter int CNT_W = 10,
  parameter int NF    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             timer_mode,
  input logic             sel_q,
  input logic             centre_q,
  input logic             load,
  input logic [CNT_W-1:0] top_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] duty_b_q,
  input logic [NF-1:0]    flag_clr,
  input logic [NF-1:0]    flags,
  input logic             oe_a,
  input logic             oe_b,
  input logic             pin_a,
  input logic             pin_b
);
  assert_sel_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q |-> !oe_a);

  assert_cnt_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= top_q));

  assert_edge_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !centre_q && cnt_q == top_q) |=> (cnt_q == '0));

  assert_centre_turn_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && centre_q && cnt_q == top_q && top_q > CNT_W'(1))
      |=> (cnt_q == $past(top_q) - 1'b1));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags & ~flag_clr)) |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));

  assert_released_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a |-> !pin_a) and (!oe_b |-> !pin_b));

  assert_timer_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timer_mode |-> (!oe_a && !oe_b));

  assert_shadow_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load) |=> ($stable(duty_b_q) && $stable(top_q)));

  assert_idle_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));

  assert_idle_no_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> ((flags & ~$past(flags)) == '0));
endmodule

bind pwm_dual_timer pwm_dual_timer_chk #(.CNT_W(CNT_W), .NF(NUM_FLAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .timer_mode(timer_mode),
  .sel_q(sel_q), .centre_q(centre_q), .load(load), .top_q(top_q),
  .cnt_q(cnt_q), .duty_b_q(duty_b_q), .flag_clr(flag_clr), .flags(flags),
  .oe_a(oe_a), .oe_b(oe_b), .pin_a(pin_a), .pin_b(pin_b)
);

// File: tb/pwm_dual_timer_bench.sv
module pwm_dual_timer_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic       timer_mode = 1'b0;
  logic       per_from_a = 1'b0;
  logic       centre_mode = 1'b0;
  logic [2:0] per_code = 3'd1;
  logic [9:0] cmp_a = '0;
  logic [9:0] cmp_b = '0;
  logic [1:0] io_a = 2'b10;
  logic [1:0] io_b = 2'b10;
  logic       act_a = 1'b1;
  logic       act_b = 1'b1;
  logic       inv_a = 1'b0;
  logic       inv_b = 1'b0;
  logic [2:0] flag_clr = '0;
  logic       pin_a, pin_b, oe_a, oe_b;
  logic [2:0] flags;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwm_dual_timer u_pwm_dual_timer (
    .clk(clk), .rst_n(rst_n), .run(run), .timer_mode(timer_mode),
    .per_from_a(per_from_a), .centre_mode(centre_mode), .per_code(per_code),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .io_a(io_a), .io_b(io_b),
    .act_a(act_a), .act_b(act_b), .inv_a(inv_a), .inv_b(inv_b),
    .flag_clr(flag_clr), .pin_a(pin_a), .pin_b(pin_b),
    .oe_a(oe_a), .oe_b(oe_b), .flags(flags)
  );

  typedef struct packed {
    logic       sel;
    logic       ctr;
    logic [2:0] code;
    logic [9:0] ca;
    logic [9:0] cb;
    logic       act;
    logic       inv;
  } vec_t;

  localparam vec_t VECS [0:8] = '{
    '{1'b0, 1'b0, 3'd1, 10'd32,   10'd100,  1'b1, 1'b0},
    '{1'b0, 1'b1, 3'd1, 10'd32,   10'd0,    1'b1, 1'b0},
    '{1'b1, 1'b0, 3'd0, 10'd20,   10'd5,    1'b1, 1'b0},
    '{1'b1, 1'b1, 3'd0, 10'd20,   10'd7,    1'b1, 1'b0},
    '{1'b0, 1'b0, 3'd1, 10'd200,  10'd128,  1'b1, 1'b1},
    '{1'b0, 1'b0, 3'd1, 10'd0,    10'd1,    1'b0, 1'b0},
    '{1'b1, 1'b0, 3'd0, 10'd0,    10'd1000, 1'b1, 1'b0},
    '{1'b0, 1'b0, 3'd0, 10'd1023, 10'd512,  1'b1, 1'b0},
    '{1'b0, 1'b0, 3'd3, 10'd383,  10'd10,   1'b0, 1'b1}
  };

  task automatic check(input string req, input int act_v, input int exp_v);
    n_chk++;
    if (act_v != exp_v) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  // Period length from R1 / R3
  function automatic int plen(input vec_t v);
    if (v.sel) return (v.ca == 0) ? 1024 : int'(v.ca);
    return (v.code == 0) ? 1024 : 128 * int'(v.code);
  endfunction

  // Active cycles in one period from R2 / R4 / R5
  function automatic int active_per(input int p, input int d, input bit ctr);
    if (d == 0) return 0;
    if (d >= p) return ctr ? 2 * p - 2 : p;
    return ctr ? 2 * d - 1 : d;
  endfunction

  function automatic int span(input int p, input bit ctr);
    return ctr ? 2 * p - 2 : p;
  endfunction

  // High samples on a PWM pin, per R8
  function automatic int highs(input int win, input int actv, input bit a, input bit i);
    return (a ^ i) ? actv : win - actv;
  endfunction

  task automatic settle_config(input vec_t v);
    run = 1'b0;
    per_from_a = v.sel; centre_mode = v.ctr; per_code = v.code;
    cmp_a = v.ca; cmp_b = v.cb;
    act_a = v.act; act_b = v.act; inv_a = v.inv; inv_b = v.inv;
    io_a = 2'b10; io_b = 2'b10;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int ha, hb, p, win;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // Reset state, run low
    check("R11 reset pin_a", int'(pin_a), 0);
    check("R11 reset pin_b", int'(pin_b), 0);
    check("R6 reset flags", int'(flags), 0);
    check("R7 reset oe_a", int'(oe_a), 1);

    // Vector table: two periods per entry
    foreach (VECS[k]) begin
      vec_t v;
      v = VECS[k];
      settle_config(v);
      p = plen(v);
      win = 2 * span(p, v.ctr);
      ha = 0; hb = 0;
      run = 1'b1;
      for (int i = 0; i < win; i++) begin
        #1;
        ha += int'(pin_a);
        hb += int'(pin_b);
        @(negedge clk);
      end
      run = 1'b0;
      if (v.sel)
        check("R3 pin A released", ha, 0);
      else
        check(v.ctr ? "R5 pin A duty" : "R2 pin A duty", ha,
              highs(win, 2 * active_per(p, int'(v.ca), v.ctr), v.act, v.inv));
      check(v.sel ? "R3 pin B duty" : (v.ctr ? "R5 pin B duty" : "R1 pin B duty"), hb,
            highs(win, 2 * active_per(p, int'(v.cb), v.ctr), v.act, v.inv));
    end

    // Forced levels
    @(negedge clk);
    io_a = 2'b00; act_a = 1'b1; inv_a = 1'b0; #1;
    check("R7 force low", int'(pin_a), 0);
    io_a = 2'b01; act_a = 1'b0; inv_a = 1'b1; #1;
    check("R7 force high ignores polarity", int'(pin_a), 1);
    io_a = 2'b11; #1;
    check("R7 release oe", int'(oe_a), 0);
    check("R7 release pin", int'(pin_a), 0);
    io_b = 2'b01; per_from_a = 1'b0; #1;
    check("R7 force high B", int'(pin_b), 1);

    // Timer mode
    flag_clr = 3'b111;
    @(negedge clk);
    flag_clr = 3'b000;
    settle_config('{1'b0, 1'b0, 3'd1, 10'd32, 10'd100, 1'b1, 1'b0});
    timer_mode = 1'b1;
    run = 1'b1;
    repeat (10) @(negedge clk);
    #1;
    check("R9 oe_a low", int'(oe_a), 0);
    check("R9 oe_b low", int'(oe_b), 0);
    check("R9 pins low", int'(pin_a | pin_b), 0);
    repeat (125) @(negedge clk);
    run = 1'b0;
    #1;
    check("R9 flags still set", int'(flags), 7);
    timer_mode = 1'b0;

    // Write-one-to-clear
    flag_clr = 3'b001;
    @(negedge clk);
    flag_clr = 3'b000; #1;
    check("R6 clear bit A", int'(flags), 6);

    // Set wins over clear: period of 1 count, duty B 0
    settle_config('{1'b1, 1'b0, 3'd0, 10'd1, 10'd0, 1'b1, 1'b0});
    run = 1'b1;
    repeat (3) @(negedge clk);
    flag_clr = 3'b011;
    @(negedge clk);
    flag_clr = 3'b000; #1;
    check("R6 set wins over clear", int'(flags[1:0]), 3);
    run = 1'b0;
    flag_clr = 3'b011;
    @(negedge clk);
    flag_clr = 3'b000; #1;
    check("R6 clear while idle", int'(flags[1:0]), 0);

    // Capture only at period start
    settle_config('{1'b1, 1'b0, 3'd0, 10'd20, 10'd5, 1'b1, 1'b0});
    run = 1'b1;
    repeat (8) @(negedge clk);
    cmp_b = 10'd15;
    hb = 0;
    for (int i = 0; i < 12; i++) begin
      #1; hb += int'(pin_b); @(negedge clk);
    end
    check("R10 old duty kept mid-period", hb, 0);
    hb = 0;
    for (int i = 0; i < 20; i++) begin
      #1; hb += int'(pin_b); @(negedge clk);
    end
    check("R10 new duty next period", hb, 15);

    // Run low forces inactive level
    run = 1'b0; #1;
    check("R11 inactive on stop", int'(pin_b), 0);
    @(negedge clk); #1;
    check("R11 held inactive", int'(pin_b), 0);
    run = 1'b1; #1;
    check("R4 restart active at count 0", int'(pin_b), 1);
    run = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule